// File: doc/BRIEF.md
# Rectangle Fill Engine

The engine carries out a single erase/fill command held in a word-addressed command memory. When idle, a `start` pulse latches a base word address. The engine then reads the opcode word and four operand words: a line width, a colour attribute and two packed corner vertices. If the opcode selects a fill, the engine removes the line-width bias from both vertices and unpacks column and row coordinates. It then writes a solid rectangle into a framebuffer that is 1280 pixels wide, one pixel per cycle.

While it runs, the engine widens a dirty rectangle held at its outputs, so a display refresh stage knows which part of the frame has changed. The pixel format is set at build time. The true-colour build maps the attribute to black, grey or white. The indexed build writes the low attribute byte as given.

Top module: `rect_fill`

## Requirements
- R1: While idle, a `start` pulse latches `cmd_base`. `busy` is high from the next cycle through the cycle in which `done` is high. `done` is a one-cycle pulse. A `start` that arrives while `busy` is high has no effect.
- R2: Word `cmd_base+0` must equal 0x411. Any other value ends the command with `done`, writes no pixels and leaves the dirty outputs unchanged.
- R3: The operands are read from these words: line width at `cmd_base+4`, attribute at `+5`, first vertex at `+6`, second vertex at `+7`. The line width is subtracted (modulo 2^32) from each vertex. The column is then bits [29:19] and the row is bits [12:3].
- R4: The scaled width is (lw+1)>>2. Rows y1 up to y2+scaled-1 are written. If y1 is not below y2+scaled, no row is written.
- R5: Each row covers columns x1 up to x2-1. If x2-x1 is greater than 1280, x2 becomes 1280. If x2 is not above x1, nothing is written.
- R6: Pixels are written one per cycle in row-major order. Each pixel's `fb_addr` is (row*1280+col) modulo 2^21.
- R7: In the true-colour build, attribute bits [23:16] select the 24-bit pixel: 0 gives 0x000000, 7 gives 0xC0C0C0, and any other value gives 0xFFFFFF.
- R8: In the indexed build, each pixel is attribute bits [7:0].
- R9: Reset sets `dirty_x_min` to 2047, `dirty_x_max` to 0, `dirty_y_min` to all ones and `dirty_y_max` to 0. Every fill command lowers `dirty_x_min` to x1 and raises `dirty_x_max` to the clamped x2, even when no pixel is written.
- R10: The dirty row bounds are widened only by the rows actually written.
- R11: `done` is high in the cycle after the last pixel write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a command |
| cmd_base | input | 16 | Word address of the command |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished (one-cycle pulse) |
| cmd_rd | output | 1 | Command memory read strobe |
| cmd_addr | output | 16 | Command memory word address |
| cmd_rdata | input | 32 | Read data, valid one cycle after `cmd_rd` |
| fb_we | output | 1 | Framebuffer write strobe |
| fb_addr | output | 21 | Linear pixel address |
| fb_wdata | output | 24 | Pixel value (8 bits in the indexed build) |
| dirty_x_min | output | 11 | Leftmost changed column |
| dirty_x_max | output | 11 | Right column bound of the changed area |
| dirty_y_min | output | 32 | Top changed row |
| dirty_y_max | output | 32 | Bottom changed row |

## Verification
The bench builds two instances. One uses the default true-colour build at 1280 columns. The other sets `TRUE_COLOR` to 0, which makes the 8-bit pass-through path reachable. Because the default width is kept, one command can exceed the 1280-column clamp and fill a full clamped row. Other commands cover a width-scaled multi-row fill, an empty column span and an empty row span.

// File: rtl/rect_fill.sv
module rect_fill #(
  parameter int FB_W       = 1280,
  parameter int FB_H       = 1024,
  parameter int DATA_W     = 32,
  parameter int CMD_AW     = 16,
  parameter bit TRUE_COLOR = 1'b1,
  parameter logic [31:0] FILL_OP = 32'h411
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CMD_AW-1:0]    cmd_base,
  output logic                 busy,
  output logic                 done,
  output logic                 cmd_rd,
  output logic [CMD_AW-1:0]    cmd_addr,
  input  logic [DATA_W-1:0]    cmd_rdata,
  output logic                 fb_we,
  output logic [$clog2(FB_W*FB_H)-1:0] fb_addr,
  output logic [(TRUE_COLOR ? 24 : 8)-1:0] fb_wdata,
  output logic [10:0]          dirty_x_min,
  output logic [10:0]          dirty_x_max,
  output logic [DATA_W-1:0]    dirty_y_min,
  output logic [DATA_W-1:0]    dirty_y_max
);
  localparam int PIX_W  = TRUE_COLOR ? 24 : 8;
  localparam int ADDR_W = $clog2(FB_W*FB_H);
  localparam int XW = 11, YW = 10, X_LSB = 19, Y_LSB = 3;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_WAIT, S_CALC, S_FILL, S_DONE} state_t;
  state_t state;

  logic [CMD_AW-1:0] base;
  logic [2:0]        idx;
  logic [DATA_W-1:0] w_op, w_lw, w_attr, w_v1, w_v2;
  logic [XW-1:0]     x0, xe, col;
  logic [DATA_W-1:0] row, row_end;
  logic [PIX_W-1:0]  color;

  logic [2:0] woff;
  assign woff     = (idx == 3'd0) ? 3'd0 : idx + 3'd3;
  assign cmd_addr = base + {{(CMD_AW-3){1'b0}}, woff};
  assign cmd_rd   = (state == S_FETCH);
  assign busy     = (state != S_IDLE);
  assign done     = (state == S_DONE);
  assign fb_we    = (state == S_FILL);
  assign fb_wdata = color;

  logic [DATA_W-1:0] lin;
  assign lin     = row * DATA_W'(FB_W) + DATA_W'(col);
  assign fb_addr = lin[ADDR_W-1:0];

  logic [DATA_W-1:0] a1, a2;
  logic [XW-1:0]     cx1, cx2, xe_c;
  logic [YW-1:0]     cy1, cy2;
  logic [DATA_W:0]   lw_p1;
  logic [DATA_W-1:0] row_end_c;
  logic signed [XW:0] span;
  logic [PIX_W-1:0]  color_c;
  logic              has_cols, has_rows;

  assign a1  = w_v1 - w_lw;
  assign a2  = w_v2 - w_lw;
  assign cx1 = a1[X_LSB +: XW];
  assign cy1 = a1[Y_LSB +: YW];
  assign cx2 = a2[X_LSB +: XW];
  assign cy2 = a2[Y_LSB +: YW];
  assign lw_p1     = {1'b0, w_lw} + {{DATA_W{1'b0}}, 1'b1};
  assign row_end_c = DATA_W'(cy2) + {1'b0, lw_p1[DATA_W:2]};
  assign span      = $signed({1'b0, cx2}) - $signed({1'b0, cx1});
  assign xe_c      = (span > $signed((XW+1)'(FB_W))) ? XW'(FB_W) : cx2;
  assign has_cols  = xe_c > cx1;
  assign has_rows  = DATA_W'(cy1) < row_end_c;

  logic unused_bits;
  generate
    if (TRUE_COLOR) begin : g_rgb
      logic [7:0] sel;
      assign sel = w_attr[23:16];
      assign color_c = (sel == 8'd0) ? 24'h000000 :
                       (sel == 8'd7) ? 24'hC0C0C0 : 24'hFFFFFF;
      assign unused_bits = ^{w_attr[DATA_W-1:24], w_attr[15:0], lin[DATA_W-1:ADDR_W], lw_p1[1:0],
                             a1[DATA_W-1:X_LSB+XW], a1[X_LSB-1:Y_LSB+YW], a1[Y_LSB-1:0],
                             a2[DATA_W-1:X_LSB+XW], a2[X_LSB-1:Y_LSB+YW], a2[Y_LSB-1:0]};
    end else begin : g_idx
      assign color_c = w_attr[7:0];
      assign unused_bits = ^{w_attr[DATA_W-1:8], lin[DATA_W-1:ADDR_W], lw_p1[1:0],
                             a1[DATA_W-1:X_LSB+XW], a1[X_LSB-1:Y_LSB+YW], a1[Y_LSB-1:0],
                             a2[DATA_W-1:X_LSB+XW], a2[X_LSB-1:Y_LSB+YW], a2[Y_LSB-1:0]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      base <= '0; idx <= '0;
      w_op <= '0; w_lw <= '0; w_attr <= '0; w_v1 <= '0; w_v2 <= '0;
      x0 <= '0; xe <= '0; col <= '0; row <= '0; row_end <= '0; color <= '0;
      dirty_x_min <= '1; dirty_x_max <= '0;
      dirty_y_min <= '1; dirty_y_max <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          base  <= cmd_base;
          idx   <= '0;
          state <= S_FETCH;
        end
        S_FETCH: state <= S_WAIT;
        S_WAIT: begin
          case (idx)
            3'd0: w_op   <= cmd_rdata;
            3'd1: w_lw   <= cmd_rdata;
            3'd2: w_attr <= cmd_rdata;
            3'd3: w_v1   <= cmd_rdata;
            default: w_v2 <= cmd_rdata;
          endcase
          if (idx == 3'd4) state <= S_CALC;
          else begin
            idx   <= idx + 3'd1;
            state <= S_FETCH;
          end
        end
        S_CALC: begin
          x0 <= cx1; col <= cx1; xe <= xe_c;
          row <= DATA_W'(cy1); row_end <= row_end_c; color <= color_c;
          if (w_op == FILL_OP) begin
            if (cx1 < dirty_x_min)  dirty_x_min <= cx1;
            if (xe_c > dirty_x_max) dirty_x_max <= xe_c;
            state <= (has_cols && has_rows) ? S_FILL : S_DONE;
          end else begin
            state <= S_DONE;
          end
        end
        S_FILL: begin
          if (row < dirty_y_min) dirty_y_min <= row;
          if (row > dirty_y_max) dirty_y_max <= row;
          if (col == xe - XW'(1)) begin
            col <= x0;
            row <= row + DATA_W'(1);
            if (row + DATA_W'(1) == row_end) state <= S_DONE;
          end else begin
            col <= col + XW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rect_fill_chk.sv
module rect_fill_chk #(
  parameter int PW = 24,
  parameter int XW = 11,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          fb_we,
  input logic [PW-1:0] fb_wdata,
  input logic [XW-1:0] dirty_x_min,
  input logic [XW-1:0] dirty_x_max,
  input logic [DW-1:0] dirty_y_min,
  input logic [DW-1:0] dirty_y_max
);
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_in_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_write_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> (busy && !done));

  assert_done_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fb_we) |-> done);

  assert_colour_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_we && $past(fb_we)) |-> $stable(fb_wdata));

  assert_dirty_x_grows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dirty_x_min <= $past(dirty_x_min)) && (dirty_x_max >= $past(dirty_x_max)));

  assert_dirty_y_grows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dirty_y_min <= $past(dirty_y_min)) && (dirty_y_max >= $past(dirty_y_max)));

  assert_dirty_y_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(dirty_y_min) && $stable(dirty_y_max)));
endmodule

bind rect_fill rect_fill_chk #(.PW(PIX_W), .XW(XW), .DW(DATA_W)) u_rect_fill_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fb_we(fb_we),
  .fb_wdata(fb_wdata), .dirty_x_min(dirty_x_min), .dirty_x_max(dirty_x_max),
  .dirty_y_min(dirty_y_min), .dirty_y_max(dirty_y_max));

// File: tb/test_rect_fill.sv
module test_rect_fill;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10ns clk = ~clk;

  logic        st24 = 1'b0, st8 = 1'b0;
  logic [15:0] cbase = '0;
  logic [31:0] cmem [64];

  logic        busy24, done24, rd24, we24;
  logic [15:0] ad24;
  logic [31:0] rdat24 = '0;
  logic [20:0] fa24;
  logic [23:0] fd24;
  logic [10:0] dxmin, dxmax;
  logic [31:0] dymin, dymax;

  logic        busy8, done8, rd8, we8;
  logic [15:0] ad8;
  logic [31:0] rdat8 = '0;
  logic [20:0] fa8;
  logic [7:0]  fd8;
  logic [10:0] mxmin, mxmax;
  logic [31:0] mymin, mymax;

  rect_fill i_rect_fill (
    .clk(clk), .rst_n(rst_n), .start(st24), .cmd_base(cbase), .busy(busy24), .done(done24),
    .cmd_rd(rd24), .cmd_addr(ad24), .cmd_rdata(rdat24), .fb_we(we24), .fb_addr(fa24),
    .fb_wdata(fd24), .dirty_x_min(dxmin), .dirty_x_max(dxmax),
    .dirty_y_min(dymin), .dirty_y_max(dymax));

  rect_fill #(.TRUE_COLOR(1'b0)) i_rect_fill_mono (
    .clk(clk), .rst_n(rst_n), .start(st8), .cmd_base(cbase), .busy(busy8), .done(done8),
    .cmd_rd(rd8), .cmd_addr(ad8), .cmd_rdata(rdat8), .fb_we(we8), .fb_addr(fa8),
    .fb_wdata(fd8), .dirty_x_min(mxmin), .dirty_x_max(mxmax),
    .dirty_y_min(mymin), .dirty_y_max(mymax));

  always @(posedge clk) begin
    if (rd24) rdat24 <= cmem[ad24[5:0]];
    if (rd8)  rdat8  <= cmem[ad8[5:0]];
  end

  int checks = 0, failures = 0;
  int cyc = 0, last_we = 0, done_cyc = 0, done_cnt = 0;
  int unsigned qa[$];
  logic [23:0] qd[$];

  always @(negedge clk) begin
    cyc++;
    if (we24) begin qa.push_back(fa24); qd.push_back(fd24); last_we = cyc; end
    if (we8)  begin qa.push_back(fa8);  qd.push_back({16'h0, fd8}); last_we = cyc; end
    if (done24 || done8) begin done_cnt++; done_cyc = cyc; end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input int b, input logic [31:0] op, input logic [31:0] lw,
                      input logic [31:0] attr, input int x1, input int y1, input int x2, input int y2);
    cmem[b]   = op;
    cmem[b+4] = lw;
    cmem[b+5] = attr;
    cmem[b+6] = ((32'(x1) << 19) | (32'(y1) << 3) | 32'h0000_8006) + lw;
    cmem[b+7] = ((32'(x2) << 19) | (32'(y2) << 3) | 32'h4000_0001) + lw;
  endtask

  task automatic run(input bit m8, input int b, input int restart_at);
    qa.delete(); qd.delete(); done_cnt = 0;
    @(negedge clk);
    cbase = 16'(b);
    if (m8) st8 = 1'b1; else st24 = 1'b1;
    @(negedge clk);
    st8 = 1'b0; st24 = 1'b0;
    for (int n = 0; n < 5000 && done_cnt == 0; n++) begin
      if (n == restart_at) begin
        @(negedge clk); cbase = 16'd8; st24 = 1'b1;
        @(negedge clk); st24 = 1'b0;
      end
      @(posedge clk);
    end
    chk(done_cnt != 0, "R1 done reached", done_cnt, 1);
    repeat (20) @(posedge clk);
  endtask

  task automatic rect(input string tag, input int x0, input int xe, input int y0, input int ye,
                      input logic [23:0] col);
    int k = 0, bad = 0;
    int unsigned ea = 0, aa = 0;
    logic [23:0] ad = '0;
    int n = (xe > x0 && ye > y0) ? (xe - x0) * (ye - y0) : 0;
    chk(qa.size() == n, {tag, " R4 R5 pixel count"}, qa.size(), n);
    if (qa.size() == n) begin
      for (int r = y0; r < ye; r++)
        for (int c = x0; c < xe; c++) begin
          if (bad == 0 && (qa[k] != ((r * 1280 + c) % (1 << 21)) || qd[k] != col)) begin
            bad = 1; ea = (r * 1280 + c) % (1 << 21); aa = qa[k]; ad = qd[k];
          end
          k++;
        end
      chk(bad == 0, {tag, " R6 address order"}, aa, ea);
      chk(bad == 0 || ad == col, {tag, " R7 R8 pixel value"}, ad, col);
      if (n > 0) chk(done_cyc == last_we + 1, "R11 done follows last write", done_cyc, last_we + 1);
    end
  endtask

  task automatic dirty(input string tag, input int xmn, input int xmx, input longint ymn, input longint ymx);
    chk(dxmin == 11'(xmn), {tag, " R9 dirty_x_min"}, dxmin, xmn);
    chk(dxmax == 11'(xmx), {tag, " R9 dirty_x_max"}, dxmax, xmx);
    chk(dymin == 32'(ymn), {tag, " R10 dirty_y_min"}, dymin, ymn);
    chk(dymax == 32'(ymx), {tag, " R10 dirty_y_max"}, dymax, ymx);
  endtask

  task automatic t_reset;
    chk(!busy24 && !done24, "R1 idle after reset", {busy24, done24}, 0);
    dirty("reset", 2047, 0, 64'hFFFF_FFFF, 0);
  endtask

  task automatic t_grey;
    load(0, 32'h411, 32'd5, 32'h0007_1234, 10, 20, 14, 22);
    run(1'b0, 0, -1);
    rect("grey R3", 10, 14, 20, 23, 24'hC0C0C0);
    dirty("grey", 10, 14, 20, 22);
  endtask

  task automatic t_badop;
    load(8, 32'h410, 32'd0, 32'h0001_0000, 0, 0, 900, 900);
    run(1'b0, 8, -1);
    chk(qa.size() == 0, "R2 wrong opcode writes", qa.size(), 0);
    dirty("R2 opcode", 10, 14, 20, 22);
  endtask

  task automatic t_nocols;
    load(16, 32'h411, 32'd0, 32'h0001_0000, 5, 3, 5, 9);
    run(1'b0, 16, -1);
    chk(qa.size() == 0, "R5 empty column span", qa.size(), 0);
    dirty("R5 empty cols", 5, 14, 20, 22);
  endtask

  task automatic t_norows;
    load(24, 32'h411, 32'd0, 32'h0001_0000, 40, 30, 44, 20);
    run(1'b0, 24, -1);
    chk(qa.size() == 0, "R4 empty row span", qa.size(), 0);
    dirty("R4 empty rows", 5, 44, 20, 22);
  endtask

  task automatic t_clamp;
    load(32, 32'h411, 32'd3, 32'h0001_0000, 100, 0, 1500, 0);
    run(1'b0, 32, -1);
    rect("clamp R5 white", 100, 1280, 0, 1, 24'hFFFFFF);
    dirty("R5 clamp", 5, 1280, 0, 22);
  endtask

  task automatic t_black;
    load(40, 32'h411, 32'd8, 32'h0000_FFFF, 0, 50, 2, 50);
    run(1'b0, 40, -1);
    rect("black R7 scaled width", 0, 2, 50, 52, 24'h000000);
    dirty("R10 black", 0, 1280, 0, 51);
  endtask

  task automatic t_restart;
    run(1'b0, 0, 3);
    rect("R1 start while busy", 10, 14, 20, 23, 24'hC0C0C0);
    chk(done_cnt == 1, "R1 single done", done_cnt, 1);
    chk(!busy24, "R1 idle after command", busy24, 0);
  endtask

  task automatic t_mono;
    load(48, 32'h411, 32'd3, 32'h0007_00A5, 2, 4, 5, 4);
    run(1'b1, 48, -1);
    rect("mono R8", 2, 5, 4, 5, 24'h0000A5);
    chk(mxmin == 11'd2 && mxmax == 11'd5, "R8 R9 mono dirty x", {mxmin, mxmax}, {11'd2, 11'd5});
    chk(mymin == 32'd4 && mymax == 32'd4, "R8 R10 mono dirty y", mymin, 4);
  endtask

  initial begin
    #(20ns * 150000);
    chk(1'b0, "watchdog", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) cmem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_grey();
    t_badop();
    t_nocols();
    t_norows();
    t_clamp();
    t_black();
    t_restart();
    t_mono();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule